// File: doc/BRIEF.md
# Byte Write-Posting Buffer with Threshold DMA Requests

This block buffers a run of bytes on their way from a writer (a host processor or a DMA channel) to an external memory write port. Software programs a byte count and a space threshold, then sets a start bit. While the engine is active it accepts bytes on a valid/ready input and holds them in a 64-byte FIFO. It sends them out in arrival order, one per cycle, on a valid/ready output. After the last programmed byte has left, the engine turns itself off. Byte enables play no part: every byte the FIFO accepts is sent out.

The block reports its free space and whether that space is at or above the threshold. In DMA mode it raises a request whenever enough room exists. The request stays up until exactly that many bytes have arrived. Two sticky interrupt sources are provided: one for space and one for the end of the run. Each has its own enable bit, and both are cleared by writing a 1. Starting a new run cancels any request left over from the previous run.

Registers are write-only over `cfg_we`/`cfg_addr`/`cfg_wdata`:
- address 0 is control: bit 0 starts a run and bit 1 selects DMA mode.
- address 1 is the threshold.
- address 2 is the byte count.
- address 3 holds the interrupt enables: bit 0 for space, bit 1 for end of run.
- address 4 clears status bits: writing a 1 to a bit clears it, using the same bit positions.

Top module: `wpf_post_engine`

## Requirements
- R1: `free_bytes` always equals 64 minus the number of bytes held. It reads 64 after reset.
- R2: `thresh_ok` is 1 exactly when `free_bytes` is greater than or equal to the threshold. A threshold write of 0 is stored as 1, a write above 64 is stored as 64, and the reset threshold is 32.
- R3: Writing 1 to control bit 0 while inactive with a nonzero count makes `active` 1 on the next cycle and loads `remaining` with the count. With a zero count, or while already active, that write has no effect on `active` or `remaining`.
- R4: `in_ready` is 1 only while active, with the FIFO not full and fewer bytes accepted than the count. Bytes offered while inactive are not taken and leave `free_bytes` unchanged.
- R5: `out_valid` is 1 while active with the FIFO non-empty. Bytes leave in arrival order with their values unchanged. `remaining` drops by one for each byte taken on the output.
- R6: When the byte taken on the output leaves `remaining` at 0, `active` is 0 on the next cycle.
- R7: `irq_status` bit 0 is set when that cycle had space enable (bit 0) set, the engine active, and `thresh_ok` at 1.
- R8: `irq_status` bit 1 is set when the last byte of a run is posted while end-of-run enable (bit 1) is set.
- R9: Status bits stay set until a 1 is written to the same bit at address 4. A set condition in the same cycle wins over the clear. `irq` is the OR of each status bit ANDed with its enable.
- R10: With DMA mode on, the engine active and `thresh_ok` at 1, `dma_req` rises on the next cycle if it is low.
- R11: Once high, `dma_req` stays high until exactly as many bytes have been accepted as the threshold held when it rose. It is then low for at least one cycle.
- R12: A start that launches a run clears `dma_req`, including a request left pending from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Writer offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| out_valid | output | 1 | Byte available to memory |
| out_data | output | 8 | Byte to memory |
| out_ready | input | 1 | Memory takes the byte |
| free_bytes | output | 7 | Empty byte places |
| thresh_ok | output | 1 | Free space at or above threshold |
| active | output | 1 | Engine running |
| remaining | output | 14 | Bytes still to post (meaningful while active) |
| dma_req | output | 1 | DMA request |
| irq_status | output | 2 | Sticky status: bit 0 space, bit 1 end of run |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a DMA request stranded at the end of a run. This happens when the count is not a multiple of the threshold: the final request can never be satisfied and stays high after the engine stops, until the next start cancels it. The bench steers into this case directly with a count of 10 and a threshold of 8. It also fills the FIFO completely with the output stalled, which exercises a full stall and the clamping of a zero threshold. Randomized runs then mix DMA and host modes, sparse and dense traffic on both sides, status clears issued at random, and restart attempts made mid-run.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
    localparam int FIFO_DEPTH = 64;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = 14;
    localparam int CFG_W      = 16;

    localparam int IRQ_SPACE  = 0;
    localparam int IRQ_TERM   = 1;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_THR   = 3'd1,
        REG_COUNT = 3'd2,
        REG_IEN   = 3'd3,
        REG_ICLR  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic       dma_mode;
        logic [1:0] ien;
    } ctrl_t;

    function automatic int unsigned clamp_thr(input logic [CFG_W-1:0] v,
                                              input int unsigned depth);
        if (v == '0) return 1;
        if (32'(v) > depth) return depth;
        return 32'(v);
    endfunction
endpackage

// File: rtl/wpf_fifo.sv
module wpf_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full  = (level == PW'(DEPTH));
    assign empty = (level == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
            case ({push, pop})
                2'b10:   level <= level + PW'(1);
                2'b01:   level <= level - PW'(1);
                default: level <= level;
            endcase
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R1
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(level));
endmodule

// File: rtl/wpf_dma.sv
module wpf_dma #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_mode,
    input  logic          active,
    input  logic          thresh_ok,
    input  logic [PW-1:0] thr,
    input  logic          launch,
    input  logic          push,
    output logic          req
);
    logic [PW-1:0] got;
    logic [PW-1:0] len;

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            req <= 1'b0;
            got <= '0;
            len <= '0;
        end else if (req) begin
            if (push) begin
                if ((got + PW'(1)) == len) begin
                    req <= 1'b0;
                    got <= '0;
                end else begin
                    got <= got + PW'(1);
                end
            end
        end else if (dma_mode && active && thresh_ok) begin
            req <= 1'b1;
            got <= '0;
            len <= thr;
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !push && !launch) |=> req);
    // R12
    start_flush_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> !req);
    // R10
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(dma_mode && active && thresh_ok));
endmodule

// File: rtl/wpf_irq.sv
module wpf_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] en,
    input  logic [1:0] set_cond,
    input  logic [1:0] clr,
    output logic [1:0] status,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | (set_cond & en);
    end

    assign irq = |(status & en);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !clr[1]) |=> status[1]);
    // R8
    term_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_cond[1] && en[1]) |=> status[1]);
    // R7
    space_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_cond[0] && en[0]) |=> status[0]);
endmodule

// File: rtl/wpf_post_engine.sv
module wpf_post_engine
    import wpf_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int CW    = CNT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [2:0]                  cfg_addr,
    input  logic [CFG_W-1:0]            cfg_wdata,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    output logic                        in_ready,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_data,
    input  logic                        out_ready,
    output logic [$clog2(DEPTH+1)-1:0]  free_bytes,
    output logic                        thresh_ok,
    output logic                        active,
    output logic [CW-1:0]               remaining,
    output logic                        dma_req,
    output logic [1:0]                  irq_status,
    output logic                        irq
);
    localparam int PW = $clog2(DEPTH+1);

    ctrl_t         ctrl;
    logic [PW-1:0] thr;
    logic [CW-1:0] xfer_cnt;
    logic [CW-1:0] left;
    logic [PW-1:0] level;
    logic          full, empty;
    logic          push, pop, launch, last_post;
    logic [1:0]    clr;

    // register writes
    assign launch = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0]
                    && !active && (xfer_cnt != '0);
    assign clr    = (cfg_we && (cfg_addr == REG_ICLR)) ? cfg_wdata[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            thr      <= PW'(DEPTH/2);
            xfer_cnt <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL:  ctrl.dma_mode <= cfg_wdata[1];
                REG_THR:   thr           <= PW'(clamp_thr(cfg_wdata, DEPTH));
                REG_COUNT: xfer_cnt      <= cfg_wdata[CW-1:0];
                REG_IEN:   ctrl.ien      <= cfg_wdata[1:0];
                default:   ;
            endcase
        end
    end

    // handshakes
    assign in_ready  = active && !full && (left != '0);
    assign out_valid = active && !empty;
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;
    assign last_post = pop && (remaining == CW'(1));

    // run state
    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            remaining <= '0;
            left      <= '0;
        end else if (launch) begin
            active    <= 1'b1;
            remaining <= xfer_cnt;
            left      <= xfer_cnt;
        end else begin
            if (last_post)        active    <= 1'b0;
            if (pop)              remaining <= remaining - CW'(1);
            if (push)             left      <= left - CW'(1);
        end
    end

    assign free_bytes = PW'(DEPTH) - level;
    assign thresh_ok  = (free_bytes >= thr);

    wpf_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(in_data), .pop(pop),
        .dout(out_data), .level(level), .full(full), .empty(empty)
    );

    wpf_dma #(.PW(PW)) u_dma (
        .clk(clk), .rst(rst), .dma_mode(ctrl.dma_mode), .active(active),
        .thresh_ok(thresh_ok), .thr(thr), .launch(launch), .push(push),
        .req(dma_req)
    );

    wpf_irq u_irq (
        .clk(clk), .rst(rst), .en(ctrl.ien),
        .set_cond({last_post, active && thresh_ok}),
        .clr(clr), .status(irq_status), .irq(irq)
    );

    // R6
    autostop_chk: assert property (@(posedge clk) disable iff (rst)
        last_post |=> !active);
    // R3
    launch_load_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> (active && remaining == $past(xfer_cnt)));
    // R4
    idle_block_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !in_ready);
    // R5
    post_count_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !last_post) |=> (remaining == $past(remaining) - CW'(1)));
endmodule

// File: tb/wpf_post_engine_test.sv
module wpf_post_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready;
    logic [6:0]  free_bytes;
    logic        thresh_ok;
    logic        active;
    logic [13:0] remaining;
    logic        dma_req;
    logic [1:0]  irq_status;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int p_in  = 70;
    int p_out = 70;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpf_post_engine uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .free_bytes(free_bytes), .thresh_ok(thresh_ok),
        .active(active), .remaining(remaining), .dma_req(dma_req),
        .irq_status(irq_status), .irq(irq)
    );

    // reference model state
    logic [7:0]  mq[$];
    bit          m_active, m_dma, m_req;
    int          m_rem, m_left, m_thr, m_cnt, m_got, m_len;
    bit [1:0]    m_en, m_st;

    function automatic int e_free();     return 64 - mq.size(); endfunction
    function automatic bit e_tok();      return e_free() >= m_thr; endfunction
    function automatic bit e_in_ready(); return m_active && mq.size() < 64 && m_left > 0; endfunction
    function automatic bit e_out_valid(); return m_active && mq.size() > 0; endfunction
    function automatic int clampv(input int v);
        if (v == 0) return 1;
        if (v > 64) return 64;
        return v;
    endfunction

    always @(posedge clk) begin
        bit acc, post, start_evt, last;
        bit [1:0] clr;
        if (rst) begin
            mq.delete();
            m_active = 0; m_dma = 0; m_req = 0; m_rem = 0; m_left = 0;
            m_thr = 32; m_cnt = 0; m_got = 0; m_len = 0; m_en = 0; m_st = 0;
        end else begin
            acc       = in_valid && e_in_ready();
            post      = e_out_valid() && out_ready;
            last      = post && (m_rem == 1);
            start_evt = cfg_we && cfg_addr == 3'd0 && cfg_wdata[0] && !m_active && m_cnt != 0;
            clr       = (cfg_we && cfg_addr == 3'd4) ? cfg_wdata[1:0] : 2'b00;
            // status uses pre-edge values
            m_st[0] = (m_st[0] && !clr[0]) || (m_en[0] && m_active && e_tok());
            m_st[1] = (m_st[1] && !clr[1]) || (m_en[1] && last);
            // dma
            if (start_evt) begin
                m_req = 0; m_got = 0; m_len = 0;
            end else if (m_req) begin
                if (acc) begin
                    if (m_got + 1 == m_len) begin m_req = 0; m_got = 0; end
                    else m_got = m_got + 1;
                end
            end else if (m_dma && m_active && e_tok()) begin
                m_req = 1; m_got = 0; m_len = m_thr;
            end
            // run state
            if (start_evt) begin
                m_active = 1; m_rem = m_cnt; m_left = m_cnt;
            end else begin
                if (last) m_active = 0;
                if (post) m_rem = m_rem - 1;
                if (acc)  m_left = m_left - 1;
            end
            if (post) void'(mq.pop_front());
            if (acc)  mq.push_back(in_data);
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_dma = cfg_wdata[1];
                    3'd1: m_thr = clampv(int'(cfg_wdata));
                    3'd2: m_cnt = int'(cfg_wdata[13:0]);
                    3'd3: m_en  = cfg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1 free_bytes", int'(free_bytes), e_free());
        chk("R2 thresh_ok", int'(thresh_ok), int'(e_tok()));
        chk("R3 active", int'(active), int'(m_active));
        chk("R4 in_ready", int'(in_ready), int'(e_in_ready()));
        chk("R5 out_valid", int'(out_valid), int'(e_out_valid()));
        if (e_out_valid()) chk("R5 out_data", int'(out_data), int'(mq[0]));
        if (m_active) chk("R5 remaining", int'(remaining), m_rem);
        chk("R7 space status", int'(irq_status[0]), int'(m_st[0]));
        chk("R8 term status", int'(irq_status[1]), int'(m_st[1]));
        chk("R9 irq", int'(irq), int'(|(m_st & m_en)));
        chk("R10 R11 R12 dma_req", int'(dma_req), int'(m_req));
    endtask

    task automatic next_cycle();
        @(negedge clk);
        check_all();
        cfg_we    = 0;
        in_valid  = ($urandom % 100) < p_in;
        in_data   = 8'($urandom);
        out_ready = ($urandom % 100) < p_out;
    endtask

    task automatic wr(input int addr, input int data);
        next_cycle();
        cfg_we    = 1;
        cfg_addr  = 3'(addr);
        cfg_wdata = 16'(data);
    endtask

    task automatic run_job(input int cnt, input int thr, input bit dma,
                           input int en, input int pi, input int po);
        p_in = pi; p_out = po;
        wr(1, thr);
        wr(2, cnt);
        wr(4, 3);
        wr(3, en);
        wr(0, {dma, 1'b1});
        for (int k = 0; k < 4000; k++) begin
            next_cycle();
            if (!m_active) break;
            if ($urandom % 20 == 0) begin
                cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = 16'($urandom % 4);
            end else if ($urandom % 50 == 0 && m_rem > 2) begin
                cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = {14'd0, dma, 1'b1};
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        in_valid = 0; in_data = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // reset state
        @(negedge clk);
        chk("R1 reset free", int'(free_bytes), 64);
        chk("R3 reset inactive", int'(active), 0);
        chk("R9 reset irq", int'(irq), 0);
        chk("R10 reset dma_req", int'(dma_req), 0);

        // R4: writes while inactive are ignored
        p_in = 100; p_out = 100;
        repeat (5) next_cycle();
        chk("R4 idle in_ready", int'(in_ready), 0);
        chk("R4 idle free", int'(free_bytes), 64);

        // R2: over-range threshold clamps to 64
        wr(1, 200);
        next_cycle();
        chk("R2 clamp high thresh_ok", int'(thresh_ok), 1);

        // R3: zero count start ignored
        wr(2, 0);
        wr(0, 1);
        next_cycle();
        next_cycle();
        chk("R3 zero count no start", int'(active), 0);

        // full stall, then threshold 0 clamps to 1
        p_in = 100; p_out = 0;
        wr(1, 16);
        wr(2, 100);
        wr(0, 1);
        repeat (80) next_cycle();
        chk("R4 full stall in_ready", int'(in_ready), 0);
        chk("R1 full free", int'(free_bytes), 0);
        wr(1, 0);
        next_cycle();
        chk("R2 clamp zero thresh_ok", int'(thresh_ok), 0);
        p_out = 100;
        for (int k = 0; k < 400 && m_active; k++) next_cycle();
        chk("R6 stopped after run", int'(active), 0);

        // R12: stranded request flushed by next start
        run_job(10, 8, 1'b1, 0, 100, 100);
        repeat (3) next_cycle();
        chk("R12 stranded request pending", int'(dma_req), 1);
        wr(2, 5);
        wr(0, 3);
        next_cycle();
        chk("R12 start flushes request", int'(dma_req), 0);
        for (int k = 0; k < 200 && m_active; k++) next_cycle();

        // R8/R9 directed: terminal status with enable
        run_job(3, 4, 1'b0, 2, 100, 100);
        repeat (2) next_cycle();
        chk("R8 term status set", int'(irq_status[1]), 1);
        chk("R9 irq from term", int'(irq), 1);
        wr(4, 2);
        next_cycle();
        chk("R9 w1c clears term", int'(irq_status[1]), 0);

        // random runs
        for (int j = 0; j < 24; j++) begin
            run_job(1 + ($urandom % 200), $urandom % 70, 1'($urandom),
                    $urandom % 4, 10 + ($urandom % 91), 10 + ($urandom % 91));
            repeat (2) next_cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule